// File: doc/BRIEF.md
# Burst Write Port for Block RAM

This block is an AXI4 slave that handles only the write side of the bus: the write address, write data and write response channels. It takes one burst at a time and records the start address, beat count, beat size and burst kind. Each data beat it accepts becomes one write into a single-port synchronous RAM, using the beat's strobes as byte enables. When the final beat has been taken, it returns one response.

The address channel is ready whenever the block is idle, so an address can be taken in the same cycle it is offered. The data channel stays closed until an address is held. A master that presents data before an address is therefore stalled: the block never buffers that data. A behavioural RAM array sits inside the block. Its contents can be read combinationally through a separate inspection port.

Top module: `axi_burst_wr_ram`

## Requirements
- R1: After reset, and after every completed response handshake, `awready` is high while no burst is held, so an address offered with `awvalid` is captured at the first rising edge with no added wait.
- R2: From the edge that captures an address until the edge that completes the response handshake, `awready` is low, and at most one of `awready`, `wready` and `bvalid` is high in any cycle.
- R3: `wready` is low until an address has been captured. A beat offered on `wvalid` before that writes nothing and waits.
- R4: Every edge where `wvalid` and `wready` are both high writes one RAM word. Strobe bit n enables bits 8n+7 down to 8n of that word. A beat with all strobes zero changes no memory.
- R5: The RAM word written is the byte address divided by DATA_W/8. For `awburst` 2'b01 (incrementing), the byte address grows by 2 to the power `awsize` after each beat and wraps modulo 2^ADDR_W. For `awburst` 2'b00 (fixed), it stays at the captured value.
- R6: After `awlen`+1 beats have been accepted, `wready` falls and `bvalid` rises on that same edge, without waiting for `bready`.
- R7: `bvalid` stays high, with a stable `bid`, until an edge where `bready` is high. `bid` equals the `awid` captured for the burst, and `bresp` is 2'b00.
- R8: While `rst_n` is low, `awready`, `wready` and `bvalid` are all low. `awready` goes high at the first rising edge after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| awid | input | ID_W | Burst identifier |
| awaddr | input | ADDR_W | Start byte address |
| awlen | input | 8 | Beats in burst minus one |
| awsize | input | 3 | Log2 of bytes per beat |
| awburst | input | 2 | 00 fixed, 01 incrementing |
| awvalid | input | 1 | Address valid |
| awready | output | 1 | Address ready |
| wdata | input | DATA_W | Beat data |
| wstrb | input | DATA_W/8 | Byte lane enables |
| wlast | input | 1 | Final beat marker |
| wvalid | input | 1 | Data valid |
| wready | output | 1 | Data ready |
| bid | output | ID_W | Response identifier |
| bresp | output | 2 | Response code |
| bvalid | output | 1 | Response valid |
| bready | input | 1 | Response ready |
| dbg_idx | input | ADDR_W-log2(DATA_W/8) | RAM word index to inspect |
| dbg_rdata | output | DATA_W | RAM word at `dbg_idx` |

## Verification
The bench offers data several cycles before any address. A design that buffered that beat or opened `wready` early would write memory the bench never expects to change. It also runs fixed bursts and an incrementing burst that wraps past the top of the address space; an address unit that stepped a fixed burst or failed to wrap would place words at the wrong index. Single-beat bursts and all-zero strobes expose off-by-one beat counting and lanes written without an enable. The bench also holds `bready` low for random spans, which catches a response that drops or changes `bid` before its handshake.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_RESP = 2'd2
  } wr_phase_e;

  localparam logic [1:0] BURST_FIXED = 2'b00;
  localparam logic [1:0] BURST_INCR  = 2'b01;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
endpackage

// File: rtl/wrb_addr_unit.sv
module wrb_addr_unit #(
  parameter int ADDR_W = 10,
  parameter int OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [2:0]        load_size,
  input  logic [1:0]        load_burst,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-OFF_W-1:0] word_idx
);
  import wrb_pkg::*;

  logic [2:0] size_q;
  logic [1:0] burst_q;

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a,
    input logic [2:0]        sz,
    input logic [1:0]        kind
  );
    logic [ADDR_W-1:0] inc;
    inc = '0;
    inc[sz] = 1'b1;
    if (kind == BURST_FIXED) return a;
    return a + inc;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      size_q   <= '0;
      burst_q  <= BURST_INCR;
    end else if (load) begin
      cur_addr <= load_addr;
      size_q   <= load_size;
      burst_q  <= load_burst;
    end else if (advance) begin
      cur_addr <= step_addr(cur_addr, size_q, burst_q);
    end
  end

  assign word_idx = cur_addr[ADDR_W-1:OFF_W];

  // R5
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !load && burst_q == BURST_FIXED) |=> $stable(cur_addr));
endmodule

// File: rtl/wrb_ctrl.sv
module wrb_ctrl #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             awvalid,
  input  logic [ID_W-1:0]  awid,
  input  logic [LEN_W-1:0] awlen,
  input  logic             wvalid,
  input  logic             wlast,
  input  logic             bready,
  output logic             awready,
  output logic             wready,
  output logic             bvalid,
  output logic [ID_W-1:0]  bid,
  output logic             aw_fire,
  output logic             w_fire,
  output logic             last_beat
);
  import wrb_pkg::*;

  wr_phase_e        phase;
  logic             live;
  logic [LEN_W-1:0] beat_cnt;
  logic [LEN_W-1:0] len_q;

  assign awready   = live && (phase == PH_IDLE);
  assign wready    = (phase == PH_DATA);
  assign bvalid    = (phase == PH_RESP);
  assign aw_fire   = awvalid && awready;
  assign w_fire    = wvalid && wready;
  assign last_beat = (beat_cnt == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      live     <= 1'b0;
      beat_cnt <= '0;
      len_q    <= '0;
      bid      <= '0;
    end else begin
      live <= 1'b1;
      unique case (phase)
        PH_IDLE: if (aw_fire) begin
          phase    <= PH_DATA;
          len_q    <= awlen;
          beat_cnt <= '0;
          bid      <= awid;
        end
        PH_DATA: if (w_fire) begin
          beat_cnt <= beat_cnt + 1'b1;
          if (last_beat) phase <= PH_RESP;
        end
        PH_RESP: if (bready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R1
  aw_after_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && bready) |=> awready);
  // R2
  one_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({awready, wready, bvalid}));
  // R2
  aw_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aw_fire |=> !awready);
  // R3
  w_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wready) |-> $past(aw_fire));
  // R6
  resp_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_fire && last_beat) |=> (bvalid && !wready));
  // R6
  wlast_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |-> (wlast == last_beat));
  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> (bvalid && $stable(bid)));
endmodule

// File: rtl/wrb_ram.sv
module wrb_ram #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_W-1:0]    widx,
  input  logic [DATA_W/8-1:0] wstrb,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [IDX_W-1:0]    ridx,
  output logic [DATA_W-1:0]   rdata
);
  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (we && wstrb[g]) mem[widx][8*g +: 8] <= wdata[8*g +: 8];
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/axi_burst_wr_ram.sv
module axi_burst_wr_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int IDX_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   awid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic [7:0]        awlen,
  input  logic [2:0]        awsize,
  input  logic [1:0]        awburst,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wstrb,
  input  logic              wlast,
  input  logic              wvalid,
  output logic              wready,
  output logic [ID_W-1:0]   bid,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [DATA_W-1:0] dbg_rdata
);
  import wrb_pkg::*;

  logic              aw_fire;
  logic              w_fire;
  logic              last_beat;
  logic [ADDR_W-1:0] cur_addr;
  logic [IDX_W-1:0]  word_idx;

  wrb_ctrl #(.ID_W(ID_W), .LEN_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .awvalid(awvalid), .awid(awid), .awlen(awlen),
    .wvalid(wvalid), .wlast(wlast), .bready(bready),
    .awready(awready), .wready(wready), .bvalid(bvalid), .bid(bid),
    .aw_fire(aw_fire), .w_fire(w_fire), .last_beat(last_beat)
  );

  wrb_addr_unit #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .load(aw_fire), .load_addr(awaddr), .load_size(awsize),
    .load_burst(awburst), .advance(w_fire),
    .cur_addr(cur_addr), .word_idx(word_idx)
  );

  wrb_ram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ram (
    .clk(clk), .we(w_fire), .widx(word_idx), .wstrb(wstrb),
    .wdata(wdata), .ridx(dbg_idx), .rdata(dbg_rdata)
  );

  assign bresp = RESP_OKAY;

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !(awready || wready || bvalid));
  // R4
  beat_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_fire |-> !$past(awready) || $past(aw_fire));
endmodule

// File: tb/axi_burst_wr_ram_bench.sv
`timescale 1ns/1ps
module axi_burst_wr_ram_bench;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int WORDS  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ID_W-1:0] awid = '0;
  logic [ADDR_W-1:0] awaddr = '0;
  logic [7:0] awlen = '0;
  logic [2:0] awsize = '0;
  logic [1:0] awburst = '0;
  logic awvalid = 1'b0;
  logic awready;
  logic [DATA_W-1:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic wlast = 1'b0;
  logic wvalid = 1'b0;
  logic wready;
  logic [ID_W-1:0] bid;
  logic [1:0] bresp;
  logic bvalid;
  logic bready = 1'b0;
  logic [7:0] dbg_idx = '0;
  logic [DATA_W-1:0] dbg_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [WORDS];
  bit          known [WORDS];

  always #2 clk = ~clk;

  axi_burst_wr_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) u_axi_burst_wr_ram (
    .clk(clk), .rst_n(rst_n), .awid(awid), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wlast(wlast), .wvalid(wvalid), .wready(wready),
    .bid(bid), .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .dbg_idx(dbg_idx), .dbg_rdata(dbg_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] next_byte(input logic [ADDR_W-1:0] a,
      input logic [2:0] sz, input logic [1:0] kind);
    int step;
    if (kind == 2'b00) return a;
    step = 1;
    for (int k = 0; k < int'(sz); k++) step = step * 2;
    return ADDR_W'((int'(a) + step) % (1 << ADDR_W));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
      input logic [3:0] s);
    logic [31:0] r;
    r = old;
    for (int n = 0; n < 4; n++) if (s[n]) r[8*n +: 8] = d[8*n +: 8];
    return r;
  endfunction

  task automatic scan_mem(input string tag);
    int bad;
    int first;
    logic [31:0] got;
    logic [31:0] want;
    bad = 0;
    first = -1;
    got = '0;
    want = '0;
    for (int i = 0; i < WORDS; i++) begin
      if (known[i]) begin
        dbg_idx = 8'(i);
        #0.01;
        if (dbg_rdata !== model[i]) begin
          if (first < 0) begin first = i; got = dbg_rdata; want = model[i]; end
          bad++;
        end
      end
    end
    chk(bad == 0, "R4/R5", {tag, " memory word"}, longint'(got), longint'(want));
    @(negedge clk);
  endtask

  task automatic burst(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a0,
      input int len, input logic [2:0] sz, input logic [1:0] kind,
      input bit early, input bit zero_strobe_mid, input string tag);
    logic [ADDR_W-1:0] a;
    logic [31:0] d;
    logic [3:0] s;
    int hold;
    a = a0;
    d = $urandom;
    s = 4'($urandom);
    if (early) begin
      wvalid = 1'b1; wdata = d; wstrb = s; wlast = (len == 0);
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        // R3: no address yet, data must wait
        chk(wready == 1'b0, "R3", {tag, " wready before address"}, wready, 0);
      end
    end
    awid = id; awaddr = a0; awlen = 8'(len); awsize = sz; awburst = kind;
    awvalid = 1'b1;
    // R1: ready while idle, captured at the next edge
    chk(awready == 1'b1, "R1", {tag, " awready idle"}, awready, 1);
    @(negedge clk);
    awvalid = 1'b0;
    // R2: closed once an address is held
    chk(awready == 1'b0, "R2", {tag, " awready after capture"}, awready, 0);
    for (int b = 0; b <= len; b++) begin
      if (!(early && b == 0)) begin
        wvalid = 1'b0;
        hold = $urandom % 3;
        for (int g = 0; g < hold; g++) @(negedge clk);
        d = $urandom;
        s = (zero_strobe_mid && b == 1) ? 4'h0 : 4'($urandom);
        wvalid = 1'b1; wdata = d; wstrb = s; wlast = (b == len);
      end
      while (wready !== 1'b1) @(negedge clk);
      // R6: no response before the final beat
      chk(bvalid == 1'b0, "R6", {tag, " bvalid before last"}, bvalid, 0);
      @(negedge clk);
      model[a[ADDR_W-1:2]] = merge(known[a[ADDR_W-1:2]] ? model[a[ADDR_W-1:2]] : 32'h0, d, s);
      if (!known[a[ADDR_W-1:2]]) begin
        // only lanes actually written are known; track fully-written words
        known[a[ADDR_W-1:2]] = (s == 4'hF);
      end
      a = next_byte(a, sz, kind);
    end
    wvalid = 1'b0; wlast = 1'b0;
    // R6
    chk(bvalid == 1'b1, "R6", {tag, " bvalid after last"}, bvalid, 1);
    chk(wready == 1'b0, "R6", {tag, " wready after last"}, wready, 0);
    // R7
    chk(bid == id, "R7", {tag, " bid"}, bid, id);
    chk(bresp == 2'b00, "R7", {tag, " bresp"}, bresp, 0);
    hold = $urandom % 4;
    for (int g = 0; g < hold; g++) begin
      @(negedge clk);
      chk(bvalid == 1'b1 && bid == id, "R7", {tag, " response held"}, bvalid, 1);
    end
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
    chk(bvalid == 1'b0, "R7", {tag, " bvalid after handshake"}, bvalid, 0);
    // R1: idle again right after the response
    chk(awready == 1'b1, "R1", {tag, " awready after response"}, awready, 1);
    scan_mem(tag);
  endtask

  task automatic seed_words(input logic [ADDR_W-1:0] a0, input int n);
    // fill words with full strobes so later partial writes are checkable
    logic [ADDR_W-1:0] a;
    a = a0;
    awid = 4'h0; awaddr = a0; awlen = 8'(n - 1); awsize = 3'd2; awburst = 2'b01;
    awvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0;
    for (int b = 0; b < n; b++) begin
      wdata = $urandom; wstrb = 4'hF; wlast = (b == n - 1); wvalid = 1'b1;
      @(negedge clk);
      model[a[ADDR_W-1:2]] = wdata;
      known[a[ADDR_W-1:2]] = 1'b1;
      a = next_byte(a, 3'd2, 2'b01);
    end
    wvalid = 1'b0; wlast = 1'b0;
    bready = 1'b1;
    @(negedge clk);
    bready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < WORDS; i++) begin known[i] = 1'b0; model[i] = '0; end
    repeat (3) @(negedge clk);
    // R8: everything quiet in reset
    chk(!awready && !wready && !bvalid, "R8", "outputs in reset",
        {awready, wready, bvalid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(awready == 1'b1, "R8", "awready after release", awready, 1);

    seed_words(10'h000, 64);
    seed_words(10'h100, 64);
    seed_words(10'h200, 64);
    seed_words(10'h300, 64);

    // R6 single beat
    burst(4'h3, 10'h010, 0, 3'd2, 2'b01, 1'b0, 1'b0, "single");
    // R3 data offered before any address
    burst(4'h5, 10'h040, 2, 3'd2, 2'b01, 1'b1, 1'b0, "early");
    // R5 fixed burst keeps its word
    burst(4'h6, 10'h084, 4, 3'd2, 2'b00, 1'b0, 1'b0, "fixed");
    // R4 all-zero strobe in the middle
    burst(4'h7, 10'h0C0, 3, 3'd2, 2'b01, 1'b0, 1'b1, "zerostrb");
    // R5 wrap past the top of the space
    burst(4'h8, 10'h3F8, 3, 3'd2, 2'b01, 1'b0, 1'b0, "wrap");
    // R5 narrow byte steps
    burst(4'h9, 10'h121, 5, 3'd0, 2'b01, 1'b0, 1'b0, "narrow");

    for (int t = 0; t < 30; t++) begin
      burst(4'($urandom), 10'($urandom) & 10'h3FC, $urandom % 8,
            3'($urandom % 3), 2'($urandom % 2), ($urandom % 4) == 0,
            ($urandom % 4) == 0, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule